// File: doc/BRIEF.md
# Paged PHY Register Configuration Sequencer

This block brings an external Ethernet PHY out of reset with no processor involved. It owns a Clause 22 management bus: it produces the management clock and drives the bidirectional data line through separate output, output-enable and input signals. A fixed list of management transactions is then issued to the PHY at address 0. The list programs the link speed and auto-negotiation, switches the PHY to register page 2, and patches the RGMII clock-skew bits of a paged register with a read-modify-write. It then goes back to page 0 and restarts auto-negotiation.

The list runs once after reset. It runs again each time the update strobe is pulsed, and takes the two-bit speed selection at the start of each run. A done flag reports that the last run finished cleanly. A sticky error flag reports that the PHY failed to answer a read, and the run stops at that point.

Top module: `phy_page_cfg`

## Requirements
- R1: While reset is high and in the first cycle after it, `cfg_done`, `cfg_error`, `mdio_oe` and `mdc` are all 0. A run starts by itself once reset is released.
- R2: Every transaction is a 64-bit frame sent MSB first, made of the following fields in order. 32 preamble ones. The start pattern 01. An opcode: 01 writes and 10 reads. The 5-bit PHY address, always 0. The 5-bit register number. Two turnaround bits. 16 data bits.
- R3: `mdc` is the system clock divided by 2*HALF_DIV. The default HALF_DIV of 10 gives 2.5 MHz from 50 MHz. The master changes `mdio_o` and `mdio_oe` only together with a falling edge of `mdc`, and samples `mdio_i` on the rising edge.
- R4: Each run issues exactly six frames, one at a time, in this order: speed write to register 0, page write to register 22, read of register 21, write of register 21, page write to register 22, restart write to register 0.
- R5: The speed word written to register 0 always has bit 12 set, which enables auto-negotiation. If `speed_sel[1]`=1 (1000 Mb/s), bit 6=1 and bit 13=0, giving 0x1040. If `speed_sel`=01 (100 Mb/s), bit 13=1 and bit 6=0, giving 0x3000. If `speed_sel`=00 (10 Mb/s), both bits are 0, giving 0x1000.
- R6: The first page write carries the value 2. The second page write carries 0, so the PHY is back on page 0 after every clean run.
- R7: The value written back to register 21 equals the value read from it, with bit 5 forced to 1 and bit 4 forced to 0. All other bits are unchanged.
- R8: The restart frame writes the run's speed word to register 0 with bit 9 also set.
- R9: `cfg_done` rises after the restart frame completes. It stays high until the next `update_strobe`, which clears it in the following cycle.
- R10: A strobe that arrives during a run is remembered and starts a new run as soon as the current one ends. `cfg_done` does not rise between the two runs. `speed_sel` is sampled only when a run starts.
- R11: If `mdio_i` is not 0 at the second turnaround bit of the skew read, `cfg_error` is set and the run stops after that frame, with `cfg_done` left low. The flag stays set through later runs and is cleared only by reset.
- R12: During the turnaround and data bits of a read frame, `mdio_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_sel | input | 2 | Requested link speed, sampled at the start of a run |
| update_strobe | input | 1 | One-cycle request to run the sequence again |
| mdc | output | 1 | Management bus clock |
| mdio_o | output | 1 | Management data value driven by the block |
| mdio_oe | output | 1 | High when the block drives the management data line |
| mdio_i | input | 1 | Management data line as seen at the pin |
| cfg_done | output | 1 | Last run finished without error |
| cfg_error | output | 1 | Sticky flag: the PHY did not answer a read turnaround |

## Verification
The bench models a PHY that decodes each frame and answers reads from its own page-2 skew register. It runs the sequence over a table of speed selections paired with skew contents. The four speed codes tell apart the two bits that select 1000 Mb/s from the lone bit that selects 100 Mb/s. The skew patterns show that only bits 5 and 4 are rewritten: all zeros, all ones, a value with both bits set, and a value with both bits clear. Directed cases cover the following:
- a second strobe mid-run with a changed speed, which separates the latched request from the speed sampled at run start;
- a PHY that leaves the turnaround bit floating, which separates a clean stop from a run that carries on;
- a rerun after an error, which shows the error flag is sticky.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    localparam int FRAME_BITS = 64;
    localparam int TA_FIRST   = 46;
    localparam int TA_SECOND  = 47;
    localparam int DATA_FIRST = 48;

    localparam logic [4:0]  REG_CTRL   = 5'd0;
    localparam logic [4:0]  REG_SKEW   = 5'd21;
    localparam logic [4:0]  REG_PAGE   = 5'd22;
    localparam logic [15:0] SKEW_PAGE  = 16'd2;
    localparam logic [15:0] HOME_PAGE  = 16'd0;
    localparam logic [15:0] AN_RESTART = 16'h0200;

    typedef enum logic [1:0] {
        MD_OP_WR = 2'b01,
        MD_OP_RD = 2'b10
    } md_op_e;

    typedef struct packed {
        md_op_e      op;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] wdata;
    } md_req_t;

    typedef enum logic [1:0] {
        EN_IDLE,
        EN_DRIVE,
        EN_SAMPLE,
        EN_TAIL
    } eng_state_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SPEED,
        SQ_PAGE_SEL,
        SQ_SKEW_RD,
        SQ_SKEW_WR,
        SQ_PAGE_RST,
        SQ_RESTART
    } seq_state_e;

    // Control word for register 0: auto-negotiation on, speed bits 6 and 13
    function automatic logic [15:0] speed_word(input logic [1:0] sel);
        logic [15:0] w;
        w = 16'h1000;
        if (sel[1])      w[6]  = 1'b1;
        else if (sel[0]) w[13] = 1'b1;
        return w;
    endfunction

    // Force bit 5 high (RX skew kept) and bit 4 low (TX skew off)
    function automatic logic [15:0] skew_patch(input logic [15:0] v);
        return {v[15:6], 2'b10, v[3:0]};
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(input md_req_t r);
        logic [1:0]  ta;
        logic [15:0] d;
        ta = (r.op == MD_OP_RD) ? 2'b11 : 2'b10;
        d  = (r.op == MD_OP_RD) ? 16'hFFFF : r.wdata;
        return {32'hFFFF_FFFF, 2'b01, r.op, r.phy, r.regad, ta, d};
    endfunction

    function automatic seq_state_e next_step(input seq_state_e s);
        case (s)
            SQ_SPEED:    return SQ_PAGE_SEL;
            SQ_PAGE_SEL: return SQ_SKEW_RD;
            SQ_SKEW_RD:  return SQ_SKEW_WR;
            SQ_SKEW_WR:  return SQ_PAGE_RST;
            SQ_PAGE_RST: return SQ_RESTART;
            default:     return SQ_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/mdc_clkgen.sv
module mdc_clkgen #(
    parameter int HALF_DIV = 10
) (
    input  logic clk,
    input  logic rst,
    output logic mdc,
    output logic rise_now,
    output logic fall_now
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap     = (cnt == CW'(HALF_DIV - 1));
    assign rise_now = wrap & ~mdc;
    assign fall_now = wrap & mdc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import phy_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rise_now,
    input  logic        fall_now,
    input  logic        start,
    input  md_req_t     req,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata,
    output logic        ta_err
);
    localparam int BW = $clog2(FRAME_BITS);

    eng_state_e            state;
    logic [FRAME_BITS-1:0] shreg;
    logic [BW-1:0]         bitn;
    logic                  is_rd;

    assign busy = (state != EN_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= EN_IDLE;
            shreg   <= '0;
            bitn    <= '0;
            is_rd   <= 1'b0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            done    <= 1'b0;
            rdata   <= '0;
            ta_err  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                EN_IDLE: begin
                    if (start) begin
                        shreg  <= build_frame(req);
                        bitn   <= '0;
                        is_rd  <= (req.op == MD_OP_RD);
                        ta_err <= 1'b0;
                        state  <= EN_DRIVE;
                    end
                end
                EN_DRIVE: begin
                    if (fall_now) begin
                        mdio_o  <= shreg[FRAME_BITS-1];
                        mdio_oe <= !(is_rd && (bitn >= BW'(TA_FIRST)));
                        state   <= EN_SAMPLE;
                    end
                end
                EN_SAMPLE: begin
                    if (rise_now) begin
                        if (is_rd && (bitn == BW'(TA_SECOND)) && mdio_i)
                            ta_err <= 1'b1;
                        if (is_rd && (bitn >= BW'(DATA_FIRST)))
                            rdata <= {rdata[14:0], mdio_i};
                        shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
                        if (bitn == BW'(FRAME_BITS - 1)) begin
                            state <= EN_TAIL;
                        end else begin
                            bitn  <= bitn + 1'b1;
                            state <= EN_DRIVE;
                        end
                    end
                end
                default: begin
                    if (fall_now) begin
                        mdio_o  <= 1'b1;
                        mdio_oe <= 1'b0;
                        done    <= 1'b1;
                        state   <= EN_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/phy_cfg_fsm.sv
module phy_cfg_fsm
    import phy_seq_pkg::*;
#(
    parameter logic [4:0] PHY_ADDR = 5'd0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  speed_sel,
    input  logic        update_strobe,
    input  logic        frm_done,
    input  logic        ta_err,
    input  logic [15:0] rdata,
    output logic        frm_start,
    output md_req_t     frm_req,
    output logic        cfg_done,
    output logic        cfg_error
);
    seq_state_e  state;
    logic        issued;
    logic        pending;
    logic [15:0] spd_word;
    logic [15:0] skew_val;

    always_comb begin
        frm_req.phy   = PHY_ADDR;
        frm_req.op    = MD_OP_WR;
        frm_req.regad = REG_CTRL;
        frm_req.wdata = spd_word;
        case (state)
            SQ_PAGE_SEL: begin
                frm_req.regad = REG_PAGE;
                frm_req.wdata = SKEW_PAGE;
            end
            SQ_SKEW_RD: begin
                frm_req.op    = MD_OP_RD;
                frm_req.regad = REG_SKEW;
                frm_req.wdata = '0;
            end
            SQ_SKEW_WR: begin
                frm_req.regad = REG_SKEW;
                frm_req.wdata = skew_val;
            end
            SQ_PAGE_RST: begin
                frm_req.regad = REG_PAGE;
                frm_req.wdata = HOME_PAGE;
            end
            SQ_RESTART: begin
                frm_req.wdata = spd_word | AN_RESTART;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            issued    <= 1'b0;
            pending   <= 1'b1;
            spd_word  <= '0;
            skew_val  <= '0;
            frm_start <= 1'b0;
            cfg_done  <= 1'b0;
            cfg_error <= 1'b0;
        end else begin
            frm_start <= 1'b0;
            if (update_strobe) begin
                pending  <= 1'b1;
                cfg_done <= 1'b0;
            end
            if (state == SQ_IDLE) begin
                if (pending) begin
                    pending  <= 1'b0;
                    cfg_done <= 1'b0;
                    spd_word <= speed_word(speed_sel);
                    issued   <= 1'b0;
                    state    <= SQ_SPEED;
                end
            end else if (!issued) begin
                frm_start <= 1'b1;
                issued    <= 1'b1;
            end else if (frm_done) begin
                issued <= 1'b0;
                if (state == SQ_SKEW_RD) begin
                    if (ta_err) begin
                        cfg_error <= 1'b1;
                        state     <= SQ_IDLE;
                    end else begin
                        skew_val <= skew_patch(rdata);
                        state    <= SQ_SKEW_WR;
                    end
                end else if (state == SQ_RESTART) begin
                    cfg_done <= !pending && !update_strobe;
                    state    <= SQ_IDLE;
                end else begin
                    state <= next_step(state);
                end
            end
        end
    end
endmodule

// File: rtl/phy_page_cfg.sv
module phy_page_cfg
    import phy_seq_pkg::*;
#(
    parameter int         HALF_DIV = 10,
    parameter logic [4:0] PHY_ADDR = 5'd0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] speed_sel,
    input  logic       update_strobe,
    output logic       mdc,
    output logic       mdio_o,
    output logic       mdio_oe,
    input  logic       mdio_i,
    output logic       cfg_done,
    output logic       cfg_error
);
    logic        rise_now;
    logic        fall_now;
    logic        frm_start;
    logic        frm_done;
    logic        eng_busy;
    logic        ta_err;
    logic [15:0] rdata;
    md_req_t     frm_req;

    mdc_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .mdc      (mdc),
        .rise_now (rise_now),
        .fall_now (fall_now)
    );

    mdio_frame_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .rise_now (rise_now),
        .fall_now (fall_now),
        .start    (frm_start),
        .req      (frm_req),
        .mdio_i   (mdio_i),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .busy     (eng_busy),
        .done     (frm_done),
        .rdata    (rdata),
        .ta_err   (ta_err)
    );

    phy_cfg_fsm #(.PHY_ADDR(PHY_ADDR)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .speed_sel     (speed_sel),
        .update_strobe (update_strobe),
        .frm_done      (frm_done),
        .ta_err        (ta_err),
        .rdata         (rdata),
        .frm_start     (frm_start),
        .frm_req       (frm_req),
        .cfg_done      (cfg_done),
        .cfg_error     (cfg_error)
    );
endmodule

// File: rtl/phy_page_cfg_chk.sv
module phy_page_cfg_chk (
    input logic clk,
    input logic rst,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe,
    input logic update_strobe,
    input logic cfg_done,
    input logic cfg_error,
    input logic frm_start,
    input logic eng_busy
);
    AST_MDIO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !$fell(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R3

    AST_ONE_FRAME: assert property (@(posedge clk) disable iff (rst)
        frm_start |-> !eng_busy); // R4

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cfg_done && !update_strobe) |=> cfg_done); // R9

    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        update_strobe |=> !cfg_done); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        cfg_error |=> cfg_error); // R11
endmodule

bind phy_page_cfg phy_page_cfg_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .mdc           (mdc),
    .mdio_o        (mdio_o),
    .mdio_oe       (mdio_oe),
    .update_strobe (update_strobe),
    .cfg_done      (cfg_done),
    .cfg_error     (cfg_error),
    .frm_start     (frm_start),
    .eng_busy      (eng_busy)
);

// File: tb/phy_page_cfg_tb.sv
module phy_page_cfg_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] speed_sel = 2'b00;
    logic       update_strobe = 1'b0;
    logic       mdc, mdio_o, mdio_oe, mdio_i, cfg_done, cfg_error;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    // PHY model state
    logic        phy_drv_en = 1'b0;
    logic        phy_drv    = 1'b1;
    logic        ta_bad     = 1'b0;
    logic [15:0] skew_reg   = 16'h0000;
    logic [15:0] page_reg   = 16'h0000;
    bit          conflict   = 1'b0;
    int          ones = 0;
    int          pidx = -1;
    logic [1:0]  p_op;
    logic [4:0]  p_phy, p_reg;
    logic [15:0] p_data;
    logic [1:0]  lg_op   [64];
    logic [4:0]  lg_phy  [64];
    logic [4:0]  lg_reg  [64];
    logic [15:0] lg_data [64];
    int          log_n = 0;

    assign mdio_i = mdio_oe ? mdio_o : (phy_drv_en ? phy_drv : 1'b1);

    phy_page_cfg #(.HALF_DIV(2)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .speed_sel     (speed_sel),
        .update_strobe (update_strobe),
        .mdc           (mdc),
        .mdio_o        (mdio_o),
        .mdio_oe       (mdio_oe),
        .mdio_i        (mdio_i),
        .cfg_done      (cfg_done),
        .cfg_error     (cfg_error)
    );

    always @(posedge mdc) begin
        if (pidx < 0) begin
            if (mdio_i) ones++;
            else begin
                if (ones >= 32) pidx = 0;
                ones = 0;
            end
        end else begin
            if (p_op == 2'b10 && pidx >= 13 && mdio_oe) conflict = 1'b1;
            if (pidx >= 1 && pidx <= 2)   p_op   = {p_op[0], mdio_i};
            if (pidx >= 3 && pidx <= 7)   p_phy  = {p_phy[3:0], mdio_i};
            if (pidx >= 8 && pidx <= 12)  p_reg  = {p_reg[3:0], mdio_i};
            if (pidx >= 15 && pidx <= 30) p_data = {p_data[14:0], mdio_i};
            if (pidx == 30) begin
                if (log_n < 64) begin
                    lg_op[log_n]   = p_op;
                    lg_phy[log_n]  = p_phy;
                    lg_reg[log_n]  = p_reg;
                    lg_data[log_n] = p_data;
                end
                log_n++;
                if (p_op == 2'b01) begin
                    if (p_reg == 5'd22) page_reg = p_data;
                    else if (p_reg == 5'd21 && page_reg == 16'd2) skew_reg = p_data;
                end
                pidx = -1;
                ones = 0;
            end else begin
                pidx++;
            end
        end
    end

    always @(negedge mdc) begin
        if (p_op == 2'b10 && pidx == 14) begin
            phy_drv_en = !ta_bad;
            phy_drv    = 1'b0;
        end else if (p_op == 2'b10 && pidx >= 15 && pidx <= 30) begin
            phy_drv_en = 1'b1;
            phy_drv    = (page_reg == 16'd2 && p_reg == 5'd21) ? skew_reg[30 - pidx] : 1'b0;
        end else begin
            phy_drv_en = 1'b0;
        end
    end

    // Vector table: speed code, skew content, expected reg0 word, expected skew write
    localparam logic [1:0]  T_SPD  [4] = '{2'b00, 2'b01, 2'b10, 2'b11};
    localparam logic [15:0] T_SKIN [4] = '{16'h0000, 16'hFFFF, 16'h1234, 16'hA5CF};
    localparam logic [15:0] T_REG0 [4] = '{16'h1000, 16'h3000, 16'h1040, 16'h1040};
    localparam logic [15:0] T_SKOUT[4] = '{16'h0020, 16'hFFEF, 16'h1224, 16'hA5EF};

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_frame(input int idx, input logic [1:0] op, input logic [4:0] rg,
                             input logic [15:0] d, input string req);
        if (idx >= 64 || idx >= log_n) begin
            chk(1'b0, req, 32'(log_n), 32'(idx + 1));
        end else begin
            chk(lg_op[idx] == op && lg_reg[idx] == rg && lg_phy[idx] == 5'd0 && lg_data[idx] == d,
                req, {9'd0, lg_op[idx], lg_reg[idx], lg_data[idx]}, {9'd0, op, rg, d});
        end
    endtask

    task automatic check_run(input int base, input logic [15:0] r0, input logic [15:0] sin,
                             input logic [15:0] sout);
        chk_frame(base,     2'b01, 5'd0,  r0,             "R5 speed write, first frame R4 R2");
        chk_frame(base + 1, 2'b01, 5'd22, 16'd2,          "R6 page select, second frame R4");
        chk_frame(base + 2, 2'b10, 5'd21, sin,            "R7 skew read, third frame R4");
        chk_frame(base + 3, 2'b01, 5'd21, sout,           "R7 skew write, fourth frame R4");
        chk_frame(base + 4, 2'b01, 5'd22, 16'd0,          "R6 page restore, fifth frame R4");
        chk_frame(base + 5, 2'b01, 5'd0,  r0 | 16'h0200,  "R8 restart write, sixth frame R4");
    endtask

    task automatic wait_done();
        for (int k = 0; k < 6000 && !cfg_done; k++) @(negedge clk);
    endtask

    task automatic wait_log(input int n);
        for (int k = 0; k < 6000 && log_n < n; k++) @(negedge clk);
    endtask

    task automatic pulse_strobe();
        @(negedge clk) update_strobe = 1'b1;
        @(negedge clk) update_strobe = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int base;
        int first_r;
        int second_r;
        logic prev;

        speed_sel = T_SPD[0];
        skew_reg  = T_SKIN[0];
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(!cfg_done && !cfg_error && !mdio_oe && !mdc, "R1 reset state",
            {28'd0, cfg_done, cfg_error, mdio_oe, mdc}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!cfg_done && !cfg_error && !mdio_oe && !mdc, "R1 first cycle after reset",
            {28'd0, cfg_done, cfg_error, mdio_oe, mdc}, 32'd0);

        // MDC period: expect 2*HALF_DIV = 4 system clocks
        prev = mdc; first_r = -1; second_r = -1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (mdc && !prev) begin
                if (first_r < 0) first_r = k;
                else if (second_r < 0) second_r = k;
            end
            prev = mdc;
        end
        chk(second_r - first_r == 4, "R3 mdc period", 32'(second_r - first_r), 32'd4);

        // Startup run serves vector 0 without a strobe
        wait_done();
        chk(cfg_done && log_n == 6, "R1 startup run complete", 32'(log_n), 32'd6);
        check_run(0, T_REG0[0], T_SKIN[0], T_SKOUT[0]);

        for (int i = 1; i < 4; i++) begin
            @(negedge clk);
            speed_sel = T_SPD[i];
            skew_reg  = T_SKIN[i];
            base = log_n;
            pulse_strobe();
            chk(!cfg_done, "R9 strobe clears done", {31'd0, cfg_done}, 32'd0);
            wait_done();
            chk(cfg_done && log_n == base + 6, "R4 six frames per run", 32'(log_n - base), 32'd6);
            check_run(base, T_REG0[i], T_SKIN[i], T_SKOUT[i]);
            chk(page_reg == 16'd0, "R6 page 0 after run", {16'd0, page_reg}, 32'd0);
            chk(!conflict, "R12 read released", {31'd0, conflict}, 32'd0);
        end

        // done holds while idle
        base = log_n;
        repeat (300) @(negedge clk);
        chk(cfg_done && log_n == base, "R9 done holds while idle", {31'd0, cfg_done}, 32'd1);

        // Strobe during a run is latched; speed sampled at run start
        @(negedge clk);
        speed_sel = 2'b01;
        skew_reg  = 16'h0000;
        base = log_n;
        pulse_strobe();
        wait_log(base + 1);
        @(negedge clk) speed_sel = 2'b00;
        pulse_strobe();
        wait_done();
        chk(cfg_done && log_n == base + 12, "R10 latched strobe gives second run",
            32'(log_n - base), 32'd12);
        check_run(base, 16'h3000, 16'h0000, 16'h0020);
        check_run(base + 6, 16'h1000, 16'h0020, 16'h0020);

        // Turnaround failure aborts and sets the sticky error
        @(negedge clk) ta_bad = 1'b1;
        base = log_n;
        pulse_strobe();
        for (int k = 0; k < 6000 && !cfg_error; k++) @(negedge clk);
        repeat (600) @(negedge clk);
        chk(cfg_error && !cfg_done, "R11 error set, done low",
            {30'd0, cfg_error, cfg_done}, 32'd2);
        chk(log_n == base + 3, "R11 run stops after skew read", 32'(log_n - base), 32'd3);
        ta_bad = 1'b0;
        base = log_n;
        pulse_strobe();
        wait_done();
        chk(cfg_done && cfg_error && log_n == base + 6, "R11 rerun completes, error sticky",
            {30'd0, cfg_error, cfg_done}, 32'd3);

        // Reset clears the error
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!cfg_error && !cfg_done, "R11 reset clears error",
            {30'd0, cfg_error, cfg_done}, 32'd0);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule